// File: doc/BRIEF.md
# I2C Master SCL Bit Timer with Clock-Stretch Following

This block generates the clock line of an I2C master one bit at a time. A byte-level controller pulses `bit_start`, and the timer pulls SCL low for a programmable minimum number of system-clock cycles. It then lets SCL go and reads the line back through a synchronizer. It counts the high phase only once the line has really gone high. Any target that holds SCL low therefore slows the bit down, and the timer waits for as long as the target holds the line.

The controller receives three single-cycle strobes. `drive_pt` tells it when to change SDA, `sample_pt` when to capture SDA, and `bit_done` when the bit period is complete. Two diagnostic flags describe each bit: one reports that a target stretched the clock, the other that the stretch exceeded an optional limit. The flags keep their value until the next bit is accepted. A limit of zero switches the timeout off. Even when the timeout fires, the timer keeps waiting for the line.

Top module: `scl_bit_timer`

## Requirements
- R1: After reset, `scl_pull` is 0 (SCL released), the strobes `drive_pt`, `sample_pt` and `bit_done` are 0, and both flags `stretch_seen` and `stretch_timeout` are 0.
- R2: When `bit_start` is accepted in idle, `scl_pull` goes to 1 on the next clock. It stays 1 for exactly max(`low_cycles`, 2) cycles.
- R3: `drive_pt` is a one-cycle pulse in the second cycle of the low phase, one cycle after `scl_pull` rises.
- R4: After SCL is released, `sample_pt` is never issued before the read-back line is high. It is issued exactly 3 cycles after the line rises, which covers the two-stage synchronizer and one decision register. With no target holding the line, the gap from release to `sample_pt` is therefore 3 cycles.
- R5: While the line stays low after release and `stretch_limit` is 0, the timer waits without bound. `scl_pull` stays 0, no `sample_pt` is issued, and `stretch_timeout` stays 0.
- R6: `bit_done` pulses for one cycle, max(`high_cycles`, 1) cycles after `sample_pt`. SCL stays released through the high phase, and the timer then returns to idle.
- R7: `stretch_seen` is set when the gap from release to `sample_pt` exceeds 3 cycles. It is cleared when the next bit is accepted.
- R8: With `stretch_limit` = N > 0, `stretch_timeout` is set once the released line has read low for more than N cycles, counting the two synchronizer cycles. In terms of the gap from release to `sample_pt`, the flag is set when that gap exceeds N + 1. It can be set while the timer is still waiting, and it is cleared when the next bit is accepted.
- R9: A `bit_start` pulse during a bit in progress is ignored. That bit's timing is unchanged, and no further bit follows it.
- R10: At most one of `drive_pt`, `sample_pt` and `bit_done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| low_cycles | input | CNT_W | Minimum low-phase length in system-clock cycles |
| high_cycles | input | CNT_W | Minimum high-phase length in system-clock cycles |
| stretch_limit | input | TO_W | Timeout for stretch diagnostics; 0 disables it |
| bit_start | input | 1 | Request one bit period (accepted in idle only) |
| scl_line | input | 1 | Read-back level of the SCL wire (asynchronous) |
| scl_pull | output | 1 | 1 pulls SCL low; 0 releases it |
| drive_pt | output | 1 | One-cycle strobe: time to update SDA |
| sample_pt | output | 1 | One-cycle strobe: time to capture SDA |
| bit_done | output | 1 | One-cycle strobe: bit period finished |
| stretch_seen | output | 1 | A target stretched the clock in the current bit |
| stretch_timeout | output | 1 | The stretch in the current bit exceeded the limit |

## Verification
The hardest situation to reach is a target that keeps SCL low for a precise number of cycles after the master releases it. The stretch flag and the timeout flag both have exact one-cycle boundaries. The bench models the wire as a wired-AND of the master's pull and a target hold signal. It lifts the hold a chosen number of clock edges after it sees the release, which puts each gap on either side of its threshold. A very long hold with the limit at zero shows that the timer waits without bound. A long hold with a limit of 20 shows the error rising while the timer is still waiting.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    // Phases of one bit period on the clock line.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

endpackage

// File: rtl/scl_line_sync.sv
// Synchronizer for the read-back SCL level. It resets to the released
// (high) level of an idle bus.
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s
);

    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb sh_d = {sh_q[STAGES-2:0], line_in};
        end else begin : g_single
            always_comb sh_d = line_in;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign line_s = sh_q[STAGES-1];

endmodule

// File: rtl/stretch_monitor.sv
// Counts the cycles in which the released clock line still reads low.
// It raises the stretch flag past the synchronizer allowance and the
// timeout flag past the programmed limit (a limit of 0 disables it).
module stretch_monitor #(
    parameter int TO_W      = 16,
    parameter int FREE_LOWS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            active,
    input  logic [TO_W-1:0] limit,
    output logic            stretch_flag,
    output logic            timeout_flag
);

    localparam logic [TO_W-1:0] FREE_CNT = TO_W'(FREE_LOWS);

    typedef struct packed {
        logic [TO_W-1:0] lows;
        logic            stretch;
        logic            tmo;
    } mon_t;

    mon_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (clear) begin
            m_d = '0;
        end else if (active) begin
            if (m_q.lows >= FREE_CNT)
                m_d.stretch = 1'b1;
            if ((limit != '0) && (m_q.lows >= limit))
                m_d.tmo = 1'b1;
            if (m_q.lows != '1)
                m_d.lows = m_q.lows + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign stretch_flag = m_q.stretch;
    assign timeout_flag = m_q.tmo;

endmodule

// File: rtl/scl_bit_timer.sv
// Master-side SCL bit timer. It holds the line low for at least the
// programmed low count, releases it, waits until the synchronized line
// reads high, then times the high phase.
module scl_bit_timer #(
    parameter int CNT_W       = 8,
    parameter int TO_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] low_cycles,
    input  logic [CNT_W-1:0] high_cycles,
    input  logic [TO_W-1:0]  stretch_limit,
    input  logic             bit_start,
    input  logic             scl_line,
    output logic             scl_pull,
    output logic             drive_pt,
    output logic             sample_pt,
    output logic             bit_done,
    output logic             stretch_seen,
    output logic             stretch_timeout
);

    import scl_gen_pkg::*;

    // The low phase must outlast the synchronizer so that a stale high
    // level from before the low phase cannot look like a rising edge.
    localparam logic [CNT_W-1:0] LOW_MIN  = CNT_W'(SYNC_STAGES);
    localparam logic [CNT_W-1:0] HIGH_MIN = CNT_W'(1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             pull;
        logic             drv;
        logic             smp;
        logic             done;
    } tmr_t;

    tmr_t r_d, r_q;

    logic             line_s;
    logic             mon_clear;
    logic             mon_active;
    logic [CNT_W-1:0] low_eff, high_eff;
    logic [CNT_W:0]   cnt_inc;

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (scl_line),
        .line_s  (line_s)
    );

    assign low_eff  = (low_cycles  < LOW_MIN)  ? LOW_MIN  : low_cycles;
    assign high_eff = (high_cycles < HIGH_MIN) ? HIGH_MIN : high_cycles;
    assign cnt_inc  = {1'b0, r_q.cnt} + {{CNT_W{1'b0}}, 1'b1};

    always_comb begin
        r_d       = r_q;
        r_d.drv   = 1'b0;
        r_d.smp   = 1'b0;
        r_d.done  = 1'b0;
        mon_clear = 1'b0;
        unique case (r_q.phase)
            PH_IDLE: begin
                if (bit_start) begin
                    r_d.phase = PH_LOW;
                    r_d.cnt   = '0;
                    r_d.pull  = 1'b1;
                    mon_clear = 1'b1;
                end
            end
            PH_LOW: begin
                if (r_q.cnt == '0)
                    r_d.drv = 1'b1;
                if (cnt_inc >= {1'b0, low_eff}) begin
                    r_d.phase = PH_WAIT;
                    r_d.cnt   = '0;
                    r_d.pull  = 1'b0;
                end else begin
                    r_d.cnt = cnt_inc[CNT_W-1:0];
                end
            end
            PH_WAIT: begin
                if (line_s) begin
                    r_d.phase = PH_HIGH;
                    r_d.cnt   = '0;
                    r_d.smp   = 1'b1;
                end
            end
            PH_HIGH: begin
                if (cnt_inc >= {1'b0, high_eff}) begin
                    r_d.phase = PH_IDLE;
                    r_d.cnt   = '0;
                    r_d.done  = 1'b1;
                end else begin
                    r_d.cnt = cnt_inc[CNT_W-1:0];
                end
            end
            default: r_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.phase <= PH_IDLE;
            r_q.cnt   <= '0;
            r_q.pull  <= 1'b0;
            r_q.drv   <= 1'b0;
            r_q.smp   <= 1'b0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mon_active = (r_q.phase == PH_WAIT) && !line_s;

    stretch_monitor #(.TO_W(TO_W), .FREE_LOWS(SYNC_STAGES)) u_mon (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (mon_clear),
        .active       (mon_active),
        .limit        (stretch_limit),
        .stretch_flag (stretch_seen),
        .timeout_flag (stretch_timeout)
    );

    assign scl_pull  = r_q.pull;
    assign drive_pt  = r_q.drv;
    assign sample_pt = r_q.smp;
    assign bit_done  = r_q.done;

endmodule

// File: rtl/scl_bit_timer_chk.sv
module scl_bit_timer_chk #(
    parameter int TO_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_pull,
    input logic            drive_pt,
    input logic            sample_pt,
    input logic            bit_done,
    input logic            stretch_seen,
    input logic            stretch_timeout,
    input logic [TO_W-1:0] stretch_limit,
    input logic            line_s
);

    // R3: the SDA update strobe follows the falling edge of SCL by one cycle
    a_r3_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        drive_pt |-> (scl_pull && $past(scl_pull) && !$past(scl_pull, 2)));

    // R4: sampling only after the synchronized line has been seen high
    a_r4_sample_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pt |-> ($past(line_s) && !scl_pull));

    // R6: SCL stays released when the bit period closes
    a_r6_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |-> !scl_pull);

    // R7: the stretch flag rises only while SCL is released
    a_r7_flag_while_released: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stretch_seen) |-> !scl_pull);

    // R8: the timeout flag needs a nonzero limit
    a_r8_timeout_needs_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stretch_timeout) |-> ($past(stretch_limit) != '0));

    // R10: strobes never overlap
    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drive_pt, sample_pt, bit_done}));

endmodule

bind scl_bit_timer scl_bit_timer_chk #(.TO_W(TO_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_pull        (scl_pull),
    .drive_pt        (drive_pt),
    .sample_pt       (sample_pt),
    .bit_done        (bit_done),
    .stretch_seen    (stretch_seen),
    .stretch_timeout (stretch_timeout),
    .stretch_limit   (stretch_limit),
    .line_s          (line_s)
);

// File: tb/tb_scl_bit_timer.sv
module tb_scl_bit_timer;

    localparam int CNT_W = 8;
    localparam int TO_W  = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] low_cycles = '0;
    logic [CNT_W-1:0] high_cycles = '0;
    logic [TO_W-1:0]  stretch_limit = '0;
    logic             bit_start = 1'b0;
    logic             hold = 1'b0;
    logic             scl_line;
    logic             scl_pull, drive_pt, sample_pt, bit_done;
    logic             stretch_seen, stretch_timeout;

    // Wired-AND bus: the line is high only if neither side pulls it.
    assign scl_line = !(scl_pull || hold);

    always #5 clk = ~clk;

    scl_bit_timer #(.CNT_W(CNT_W), .TO_W(TO_W), .SYNC_STAGES(2)) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .low_cycles      (low_cycles),
        .high_cycles     (high_cycles),
        .stretch_limit   (stretch_limit),
        .bit_start       (bit_start),
        .scl_line        (scl_line),
        .scl_pull        (scl_pull),
        .drive_pt        (drive_pt),
        .sample_pt       (sample_pt),
        .bit_done        (bit_done),
        .stretch_seen    (stretch_seen),
        .stretch_timeout (stretch_timeout)
    );

    typedef struct {
        int low_len;
        int rel_to_smp;
        int high_len;
        bit stretch;
        bit tmo;
    } exp_t;

    exp_t exp_q[$];
    int   errors = 0;
    int   checks = 0;
    int   strobe_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: measures each bit at the falling clock edge and pops the scoreboard.
    int tnow = 0, t_low = 0, t_drv = 0, t_rel = 0, t_smp = 0, low_len = 0;
    bit oe_prev = 1'b0;

    always @(negedge clk) begin
        tnow++;
        if (rst_n) begin
            if (!$onehot0({drive_pt, sample_pt, bit_done})) strobe_bad++;
            if (scl_pull && !oe_prev) begin t_low = tnow; low_len = 0; end
            if (scl_pull) low_len++;
            if (drive_pt) t_drv = tnow;
            if (!scl_pull && oe_prev) t_rel = tnow;
            if (sample_pt) t_smp = tnow;
            if (bit_done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected bit_done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(t_drv - t_low == 1, "R3 drive offset", t_drv - t_low, 1);
                    chk(low_len == e.low_len, "R2 low length", low_len, e.low_len);
                    chk(t_smp - t_rel == e.rel_to_smp, "R4 release-to-sample",
                        t_smp - t_rel, e.rel_to_smp);
                    chk(tnow - t_smp == e.high_len, "R6 high length",
                        tnow - t_smp, e.high_len);
                    chk(stretch_seen == e.stretch, "R7 stretch flag",
                        int'(stretch_seen), int'(e.stretch));
                    chk(stretch_timeout == e.tmo, "R8 timeout flag",
                        int'(stretch_timeout), int'(e.tmo));
                end
            end
            oe_prev = scl_pull;
        end
    end

    function automatic exp_t mk_exp(int lo, int hi, int k, int lim);
        exp_t e;
        e.low_len    = (lo < 2) ? 2 : lo;
        e.rel_to_smp = 3 + k;
        e.high_len   = (hi < 1) ? 1 : hi;
        e.stretch    = (k >= 1);
        e.tmo        = (lim != 0) && (k + 2 > lim);
        return e;
    endfunction

    // Driver: one bit, with the target holding SCL for k edges after release.
    task automatic run_bit(input int lo, input int hi, input int k, input int lim,
                           input bit poke);
        @(negedge clk);
        low_cycles    = CNT_W'(lo);
        high_cycles   = CNT_W'(hi);
        stretch_limit = TO_W'(lim);
        exp_q.push_back(mk_exp(lo, hi, k, lim));
        hold = (k > 0);
        bit_start = 1'b1;
        @(negedge clk);
        bit_start = 1'b0;
        if (poke) begin
            @(negedge clk);
            bit_start = 1'b1;   // R9: request during the low phase
            @(negedge clk);
            bit_start = 1'b0;
        end
        if (k > 0) begin
            do @(negedge clk); while (scl_pull);
            repeat (k) @(posedge clk);
            #1 hold = 1'b0;
        end
        do @(negedge clk); while (!bit_done);
        if (poke) begin
            int seen = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (scl_pull) seen++;
            end
            chk(seen == 0, "R9 no extra bit", seen, 0);
        end
    endtask

    // Driver: long hold with checks made while the timer is still waiting.
    task automatic stuck_bit(input int n, input int lim);
        int smp_seen = 0, pull_seen = 0;
        @(negedge clk);
        low_cycles    = CNT_W'(3);
        high_cycles   = CNT_W'(2);
        stretch_limit = TO_W'(lim);
        exp_q.push_back(mk_exp(3, 2, n + 1, lim));
        hold = 1'b1;
        bit_start = 1'b1;
        @(negedge clk);
        bit_start = 1'b0;
        do @(negedge clk); while (scl_pull);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sample_pt) smp_seen++;
            if (scl_pull) pull_seen++;
        end
        chk(smp_seen == 0, "R5 no sample while held", smp_seen, 0);
        chk(pull_seen == 0, "R5 line stays released", pull_seen, 0);
        if (lim == 0)
            chk(stretch_timeout == 1'b0, "R5 no timeout when disabled",
                int'(stretch_timeout), 0);
        else
            chk(stretch_timeout == 1'b1, "R8 timeout while waiting",
                int'(stretch_timeout), 1);
        @(posedge clk);
        #1 hold = 1'b0;
        do @(negedge clk); while (!bit_done);
    endtask

    bit wd_fired = 1'b0;

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                chk(scl_pull == 1'b0, "R1 reset scl_pull", int'(scl_pull), 0);
                chk({drive_pt, sample_pt, bit_done} == 3'b000, "R1 reset strobes",
                    int'({drive_pt, sample_pt, bit_done}), 0);
                chk({stretch_seen, stretch_timeout} == 2'b00, "R1 reset flags",
                    int'({stretch_seen, stretch_timeout}), 0);
                @(negedge clk);
                rst_n = 1'b1;
                repeat (2) @(negedge clk);

                run_bit(4, 4, 0, 0, 1'b0);      // R2 R4 R6 nominal
                run_bit(1, 0, 0, 0, 1'b0);      // R2 R6 minimum clamps
                run_bit(0, 0, 0, 0, 1'b0);
                run_bit(5, 3, 1, 0, 1'b0);      // R7 one-edge stretch sets flag
                run_bit(3, 3, 0, 0, 1'b0);      // R7 flag cleared on next bit
                run_bit(6, 2, 0, 0, 1'b1);      // R9 ignored request
                run_bit(3, 5, 18, 20, 1'b0);    // R8 just below limit
                run_bit(3, 5, 19, 20, 1'b0);    // R8 just above limit
                run_bit(2, 2, 0, 0, 1'b0);      // R8 flag cleared
                stuck_bit(500, 0);              // R5 unbounded wait
                stuck_bit(100, 20);             // R8 error during wait
                run_bit(255, 255, 7, 0, 1'b0);  // R2 R6 full-scale counts

                repeat (4) @(negedge clk);
                chk(exp_q.size() == 0, "R9 all bits completed", exp_q.size(), 0);
                chk(strobe_bad == 0, "R10 strobe overlap", strobe_bad, 0);
            end
            begin
                repeat (100000) @(posedge clk);
                wd_fired = 1'b1;
            end
        join_any
        disable fork;
        if (wd_fired) chk(1'b0, "watchdog expired", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule